// File: doc/BRIEF.md
# Display Controller Serial Register Master

This block is a serial master that reaches the control registers of a small display controller over a four-wire SPI link. A single command on the user side starts one access: an index write, a register write, a register read, or a status read. The block turns the command into one or two chip-select frames and shifts them out at a register-safe clock rate. When the last frame has finished, it raises a one-cycle completion pulse and, for reads, presents the returned 16-bit word.

Every frame opens with a start byte that tells the controller three things: which device is addressed, whether the frame targets the index register or register data, and the transfer direction. A register write or read needs two frames. The first loads the index. The second moves the data, and chip-select is released between the two. The status read uses one longer frame, and the controller returns an invalid byte in it that is thrown away. An optional configuration input inverts every transmitted bit for boards whose data line is inverted.

Top module: `dspi_reg_master`

## Requirements
- R1: The first byte of every frame is, from MSB to LSB, 0,1,1,1,0, then the device-ID bit, then the select bit (0 for index, 1 for data), then the direction bit (1 for read).
- R2: The link runs in SPI mode 0 with bytes MSB first. MOSI is held steady while SCLK is high. SCLK stays low whenever cs_n is high, and after reset cs_n=1, sclk=0, busy=0 and done=0.
- R3: An index write (cmd_op=0) sends one 24-bit frame: the start byte with select=0 and direction=0, then 0x00, then cmd_index.
- R4: A register write (cmd_op=1) sends the R3 index frame and then a second 24-bit frame: the start byte with select=1 and direction=0, then cmd_wdata[15:8], then cmd_wdata[7:0].
- R5: A register read (cmd_op=2) sends the R3 index frame and then a 24-bit frame whose start byte has select=1 and direction=1, followed by two 0x00 bytes. rd_data takes the two bytes received after the start byte, high byte first.
- R6: A status read (cmd_op=3) sends one 32-bit frame: the start byte with select=0 and direction=1, then three 0x00 bytes. The byte received second is discarded, and rd_data takes the last two received bytes, high byte first.
- R7: Each SCLK half-period lasts at least HALF_DIV clocks. HALF_DIV is derived from CLK_HZ and SCLK_MAX_HZ so that the SCLK rate never exceeds SCLK_MAX_HZ (50 clocks per SCLK period at the defaults).
- R8: cs_n rises at the end of every frame. Between two frames it stays high for at least one SCLK period.
- R9: When cfg_tx_invert is 1 at command acceptance, every transmitted bit of the access is inverted, including start, padding and dummy bytes. cfg_dev_id is also sampled at acceptance.
- R10: Commands are taken only while busy is 0, and a command presented while busy is ignored. done pulses for exactly one clock after the last frame. rd_data changes only when a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, accepted when busy is 0 |
| cmd_op | input | 2 | 0 index write, 1 register write, 2 register read, 3 status read |
| cmd_index | input | 8 | Register index for index write |
| cmd_wdata | input | 16 | Value for register write |
| cfg_dev_id | input | 1 | Device-ID bit placed in start bytes |
| cfg_tx_invert | input | 1 | Invert all transmitted bits |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read result |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the controller |
| miso | input | 1 | Serial data from the controller |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench models the controller as a slave that records each chip-select frame and returns a chosen word. It checks the exact bits of both frames of writes and reads. If the select and direction bits were swapped, or the device-ID bit were placed wrong, those frame comparisons would fail. For the status read, the slave returns a distinctive dummy byte, so a design that kept the wrong two bytes would show it in rd_data. The bench also measures the shortest SCLK period and the shortest chip-select high time, which exposes a divider that runs too fast or frames that run together. Finally, it presents a command while the block is busy and inverts the data line, so a design that queued the stray command or left padding bytes uninverted would send extra or wrong frames.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

    localparam int FRAME_W = 32;
    localparam int NB_W    = $clog2(FRAME_W + 1);
    localparam logic [4:0] START_PREFIX = 5'b01110;

    typedef enum logic [1:0] {
        OP_IDX_WR  = 2'd0,
        OP_REG_WR  = 2'd1,
        OP_REG_RD  = 2'd2,
        OP_STAT_RD = 2'd3
    } dspi_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } dspi_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [NB_W-1:0]    nbits;
    } dspi_frame_t;

    function automatic int calc_half_div(input longint clk_hz, input longint max_hz);
        longint q;
        q = (clk_hz + 2 * max_hz - 1) / (2 * max_hz);
        if (q < 1) q = 1;
        return int'(q);
    endfunction

    function automatic logic [7:0] start_byte(input logic id, input logic sel, input logic rd);
        return {START_PREFIX, id, sel, rd};
    endfunction

    function automatic logic has_data_frame(input dspi_op_e op);
        return (op == OP_REG_WR) || (op == OP_REG_RD);
    endfunction

    function automatic logic is_read(input dspi_op_e op);
        return (op == OP_REG_RD) || (op == OP_STAT_RD);
    endfunction

    function automatic dspi_frame_t build_frame(
        input dspi_op_e    op,
        input logic        data_phase,
        input logic        id,
        input logic [7:0]  idx,
        input logic [15:0] wd
    );
        dspi_frame_t f;
        f.nbits = NB_W'(24);
        f.bits  = {start_byte(id, 1'b0, 1'b0), 8'h00, idx, 8'h00};
        case (op)
            OP_REG_WR:
                if (data_phase) f.bits = {start_byte(id, 1'b1, 1'b0), wd, 8'h00};
            OP_REG_RD:
                if (data_phase) f.bits = {start_byte(id, 1'b1, 1'b1), 24'h000000};
            OP_STAT_RD: begin
                f.bits  = {start_byte(id, 1'b0, 1'b1), 24'h000000};
                f.nbits = NB_W'(32);
            end
            default: ;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/dspi_tick_gen.sv
module dspi_tick_gen #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/dspi_shifter.sv
module dspi_shifter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_bits,
    input  logic         invert,
    input  logic         sample,
    input  logic         advance,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= load_bits ^ {W{invert}};
            rx_q <= '0;
        end else begin
            if (advance) tx_q <= {tx_q[W-2:0], 1'b0};
            if (sample)  rx_q <= {rx_q[W-2:0], miso};
        end
    end

    assign mosi    = tx_q[W-1];
    assign rx_word = rx_q;
endmodule

// File: rtl/dspi_reg_master.sv
module dspi_reg_master
    import dspi_pkg::*;
#(
    parameter longint CLK_HZ      = 200_000_000,
    parameter longint SCLK_MAX_HZ = 4_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [7:0]  cmd_index,
    input  logic [15:0] cmd_wdata,
    input  logic        cfg_dev_id,
    input  logic        cfg_tx_invert,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n
);
    localparam int HALF_DIV = calc_half_div(CLK_HZ, SCLK_MAX_HZ);

    dspi_state_e     state_q;
    dspi_op_e        op_q;
    logic [7:0]      idx_q;
    logic [15:0]     wd_q;
    logic            id_q;
    logic            inv_q;
    logic            data_ph_q;
    logic            gap_half_q;
    logic            sclk_q;
    logic            cs_n_q;
    logic            done_q;
    logic [15:0]     rd_q;
    logic [NB_W-1:0] bitcnt_q;
    logic [NB_W-1:0] nbits_q;

    logic               tick;
    logic               idle;
    logic               accept;
    logic               more;
    logic               next_frame;
    logic               load;
    logic               last_bit;
    logic               sample;
    logic               advance;
    logic               inv_sel;
    dspi_frame_t        frame_ld;
    logic [FRAME_W-1:0] rx_word;

    assign idle       = (state_q == ST_IDLE);
    assign accept     = idle && cmd_valid;
    assign more       = has_data_frame(op_q) && !data_ph_q;
    assign next_frame = (state_q == ST_GAP) && tick && gap_half_q && more;
    assign load       = accept || next_frame;
    assign last_bit   = (bitcnt_q == nbits_q - 1'b1);
    assign sample     = (state_q == ST_SHIFT) && tick && !sclk_q;
    assign advance    = (state_q == ST_SHIFT) && tick && sclk_q && !last_bit;
    assign inv_sel    = idle ? cfg_tx_invert : inv_q;

    always_comb begin
        if (idle) begin
            frame_ld = build_frame(dspi_op_e'(cmd_op), 1'b0, cfg_dev_id, cmd_index, cmd_wdata);
        end else begin
            frame_ld = build_frame(op_q, 1'b1, id_q, idx_q, wd_q);
        end
    end

    dspi_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (!idle),
        .tick (tick)
    );

    dspi_shifter #(.W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_bits (frame_ld.bits),
        .invert    (inv_sel),
        .sample    (sample),
        .advance   (advance),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            op_q       <= OP_IDX_WR;
            idx_q      <= '0;
            wd_q       <= '0;
            id_q       <= 1'b0;
            inv_q      <= 1'b0;
            data_ph_q  <= 1'b0;
            gap_half_q <= 1'b0;
            sclk_q     <= 1'b0;
            cs_n_q     <= 1'b1;
            done_q     <= 1'b0;
            rd_q       <= '0;
            bitcnt_q   <= '0;
            nbits_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        op_q      <= dspi_op_e'(cmd_op);
                        idx_q     <= cmd_index;
                        wd_q      <= cmd_wdata;
                        id_q      <= cfg_dev_id;
                        inv_q     <= cfg_tx_invert;
                        data_ph_q <= 1'b0;
                        nbits_q   <= frame_ld.nbits;
                        bitcnt_q  <= '0;
                        cs_n_q    <= 1'b0;
                        state_q   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (last_bit) begin
                                cs_n_q     <= 1'b1;
                                gap_half_q <= 1'b0;
                                state_q    <= ST_GAP;
                            end else begin
                                bitcnt_q <= bitcnt_q + 1'b1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (!gap_half_q) begin
                            gap_half_q <= 1'b1;
                        end else if (more) begin
                            data_ph_q <= 1'b1;
                            nbits_q   <= frame_ld.nbits;
                            bitcnt_q  <= '0;
                            cs_n_q    <= 1'b0;
                            state_q   <= ST_SHIFT;
                        end else begin
                            done_q  <= 1'b1;
                            if (is_read(op_q)) rd_q <= rx_word[15:0];
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = !idle;
    assign done    = done_q;
    assign rd_data = rd_q;
    assign sclk    = sclk_q;
    assign cs_n    = cs_n_q;
endmodule

// File: rtl/dspi_reg_master_chk.sv
module dspi_reg_master_chk #(
    parameter int HALF_DIV = 25
) (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic done,
    input logic busy
);
    localparam int GAP_MIN = 2 * HALF_DIV;

    logic        sclk_d;
    logic [15:0] since_edge;
    logic [15:0] cs_high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d      <= 1'b0;
            since_edge  <= 16'(HALF_DIV);
            cs_high_cnt <= 16'(GAP_MIN);
        end else begin
            sclk_d <= sclk;
            if (sclk != sclk_d) since_edge <= 16'd1;
            else if (since_edge < 16'hFFFF) since_edge <= since_edge + 16'd1;
            if (!cs_n) cs_high_cnt <= '0;
            else if (cs_high_cnt < 16'(GAP_MIN)) cs_high_cnt <= cs_high_cnt + 16'd1;
        end
    end

    a_r2_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    a_r7_half_period: assert property (@(posedge clk) disable iff (rst)
        (sclk != sclk_d) |-> (since_edge >= 16'(HALF_DIV)));

    a_r8_cs_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (cs_high_cnt >= 16'(GAP_MIN)));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_at_rest: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && !busy));
endmodule

bind dspi_reg_master dspi_reg_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .cs_n (cs_n),
    .mosi (mosi),
    .done (done),
    .busy (busy)
);

// File: tb/sim_dspi_reg_master.sv
`timescale 1ns/1ps
module sim_dspi_reg_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [7:0]  cmd_index = 8'h00;
    logic [15:0] cmd_wdata = 16'h0000;
    logic        cfg_dev_id = 1'b1;
    logic        cfg_tx_invert = 1'b0;
    logic        busy, done, sclk, mosi, miso, cs_n;
    logic [15:0] rd_data;

    always #2.5 clk = ~clk;

    dspi_reg_master u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_index(cmd_index), .cmd_wdata(cmd_wdata), .cfg_dev_id(cfg_dev_id),
        .cfg_tx_invert(cfg_tx_invert), .busy(busy), .done(done), .rd_data(rd_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model: records frames, returns resp_q[frame] MSB first
    logic [31:0] frames [64];
    int          flen   [64];
    logic [31:0] resp_q [64];
    logic [31:0] cap = '0;
    int nb = 0, nfr = 0, t_up = 0, t_rise = 0;
    int min_gap = 1000000, min_per = 1000000;

    always @(negedge cs_n or posedge cs_n or posedge sclk) begin
        if (sclk && !cs_n) begin
            if (nb > 0 && (cyc - t_rise) < min_per) min_per = cyc - t_rise;
            t_rise = cyc;
            cap = {cap[30:0], mosi};
            nb  = nb + 1;
        end else if (cs_n === 1'b1) begin
            if (nb > 0) begin
                frames[nfr % 64] = cap;
                flen[nfr % 64]   = nb;
                nfr  = nfr + 1;
                t_up = cyc;
            end
            nb = 0;
        end else if (cs_n === 1'b0) begin
            if (nfr > 0 && (cyc - t_up) < min_gap) min_gap = cyc - t_up;
            cap = '0;
            nb  = 0;
        end
    end

    assign miso = (nb < 32) ? resp_q[nfr % 64][31 - nb] : 1'b0;

    function automatic logic [7:0] sb(input logic id, input logic sel, input logic rd);
        return {5'b01110, id, sel, rd};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic [7:0] idx, input logic [15:0] wd,
                           input logic id, input logic inv, output int base);
        int waited;
        @(negedge clk);
        while (busy) @(negedge clk);
        base = nfr;
        cfg_dev_id = id; cfg_tx_invert = inv;
        cmd_op = op; cmd_index = idx; cmd_wdata = wd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cfg_dev_id = ~id; cfg_tx_invert = ~inv;
        waited = 0;
        while (!done && waited < 20000) begin @(negedge clk); waited++; end
        check(done === 1'b1, "R10 done seen", 32'(done), 32'd1);
        @(negedge clk);
        check(done === 1'b0, "R10 done single cycle", 32'(done), 32'd0);
    endtask

    task automatic chk_frame(input int i, input int len, input logic [31:0] exp, input string tag);
        check(flen[i % 64] == len, {tag, " length"}, 32'(flen[i % 64]), 32'(len));
        check(frames[i % 64] === exp, tag, frames[i % 64], exp);
    endtask

    task automatic t_reset;
        check(cs_n === 1'b1 && sclk === 1'b0, "R2 reset cs_n/sclk", {30'd0, cs_n, sclk}, 32'd2);
        check(busy === 1'b0 && done === 1'b0, "R2 reset busy/done", {30'd0, busy, done}, 32'd0);
    endtask

    task automatic t_index_write;
        int b;
        run_cmd(2'd0, 8'h5A, 16'h0000, 1'b1, 1'b0, b);
        check(nfr - b == 1, "R3 one frame", 32'(nfr - b), 32'd1);
        chk_frame(b, 24, {8'h00, sb(1'b1, 1'b0, 1'b0), 8'h00, 8'h5A}, "R1 R3 index frame");
    endtask

    task automatic t_reg_write;
        int b;
        run_cmd(2'd1, 8'h11, 16'h4240, 1'b1, 1'b0, b);
        check(nfr - b == 2, "R4 two frames", 32'(nfr - b), 32'd2);
        chk_frame(b,     24, {8'h00, sb(1'b1, 1'b0, 1'b0), 8'h00, 8'h11}, "R4 index frame");
        chk_frame(b + 1, 24, {8'h00, sb(1'b1, 1'b1, 1'b0), 16'h4240}, "R4 data frame");
        check(rd_data === 16'h0000, "R10 rd_data held on write", 32'(rd_data), 32'h0);
    endtask

    task automatic t_reg_read;
        int b;
        resp_q[nfr % 64]       = 32'hFFFF_FFFF;
        resp_q[(nfr + 1) % 64] = 32'h00_9221_00;
        run_cmd(2'd2, 8'h00, 16'h0000, 1'b0, 1'b0, b);
        check(nfr - b == 2, "R5 two frames", 32'(nfr - b), 32'd2);
        chk_frame(b,     24, {8'h00, sb(1'b0, 1'b0, 1'b0), 16'h0000}, "R1 R5 index frame id0");
        chk_frame(b + 1, 24, {8'h00, sb(1'b0, 1'b1, 1'b1), 16'h0000}, "R5 read frame");
        check(rd_data === 16'h9221, "R5 read data", 32'(rd_data), 32'h9221);
    endtask

    task automatic t_status_read;
        int b;
        resp_q[nfr % 64] = 32'h00_A5_3C_C3;
        run_cmd(2'd3, 8'h77, 16'hFFFF, 1'b1, 1'b0, b);
        check(nfr - b == 1, "R6 one frame", 32'(nfr - b), 32'd1);
        chk_frame(b, 32, {sb(1'b1, 1'b0, 1'b1), 24'h000000}, "R6 status frame");
        check(rd_data === 16'h3CC3, "R6 status skips dummy", 32'(rd_data), 32'h3CC3);
    endtask

    task automatic t_invert;
        int b;
        run_cmd(2'd1, 8'h30, 16'h0302, 1'b1, 1'b1, b);
        chk_frame(b,     24, {8'h00, ~sb(1'b1, 1'b0, 1'b0), 8'hFF, 8'hCF}, "R9 inverted index frame");
        chk_frame(b + 1, 24, {8'h00, ~sb(1'b1, 1'b1, 1'b0), 16'hFCFD}, "R9 inverted data frame");
        resp_q[nfr % 64] = 32'h00_11_BE_EF;
        run_cmd(2'd3, 8'h00, 16'h0000, 1'b1, 1'b1, b);
        chk_frame(b, 32, {~sb(1'b1, 1'b0, 1'b1), 24'hFFFFFF}, "R9 inverted dummy bytes");
        check(rd_data === 16'hBEEF, "R9 receive not inverted", 32'(rd_data), 32'hBEEF);
    endtask

    task automatic t_busy_ignore;
        int b, waited;
        @(negedge clk);
        while (busy) @(negedge clk);
        b = nfr;
        cfg_dev_id = 1'b1; cfg_tx_invert = 1'b0;
        cmd_op = 2'd0; cmd_index = 8'h22; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (300) @(negedge clk);
        cmd_op = 2'd1; cmd_index = 8'h99; cmd_wdata = 16'hDEAD; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        waited = 0;
        while (!done && waited < 20000) begin @(negedge clk); waited++; end
        repeat (400) @(negedge clk);
        check(nfr - b == 1, "R10 busy command ignored", 32'(nfr - b), 32'd1);
        check(busy === 1'b0, "R10 idle after ignore", 32'(busy), 32'd0);
        chk_frame(b, 24, {8'h00, sb(1'b1, 1'b0, 1'b0), 8'h00, 8'h22}, "R10 original frame intact");
    endtask

    task automatic t_timing;
        check(min_per >= 49, "R7 sclk period", 32'(min_per), 32'd50);
        check(min_gap >= 49, "R8 cs_n high gap", 32'(min_gap), 32'd50);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) resp_q[i] = 32'h0;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_index_write();
        t_reg_write();
        t_reg_read();
        t_status_read();
        t_invert();
        t_busy_ignore();
        t_timing();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule